// File: doc/BRIEF.md
# Token-passing chain readout controller

This block runs one chip's turn in a chain of chips that share one open-drain data bus. It waits in idle until its start-of-readout token arrives. It then sends every stored event frame serially on the data line and marks each bit cycle with a transmit-active flag. At the end it sends a single-cycle end-of-readout pulse, which the next chip in the chain takes as its own start token. The first chip's token comes from the acquisition system.

Two start inputs and two end outputs are provided. A selector input picks which pair is live, so the chain can route around a dead neighbour. The data line and the transmit flag each come out twice and both copies always carry the same value. Every bus output is a pull-down enable. Logic 1 on an output means the pin pulls the shared line low, and 0 means the pin releases the line so the pull-up holds it high. Stored event words come in through a combinational memory read port. The chip identifier is a plain input.

Top module: `tokchain_readout`

## Requirements
- R1: During and right after reset, `dout_pd` and `txon_pd` are both 2'b00 (all lines released), and `end_a` and `end_b` are low.
- R2: Readout begins only at a clock edge where the controller is idle and the selected start input is high. The first frame bit appears on the bus in the cycle that follows that edge, and the bus stays released in the cycle of the edge itself.
- R3: With `path_sel`=0, `start_b` has no effect; with `path_sel`=1, `start_a` has no effect. A pulse on the start input that is not selected leaves the bus released and both end outputs low.
- R4: The event count is sampled at the start edge, and events 0 to n-1 are sent in order with no gap between them.
  - Each event frame is sent MSB first as these fields, in this order:
    - `chip_id`, 8 bits;
    - the low 12 bits of memory word 0 (bunch-crossing ID);
    - for channels 0 to 63 in order, memory word ch+1 as 14 bits: hit in bit 13, gain in bit 12, conversion value in bits 11:0.
  - `mem_addr` is {event index (4 bits), word index (7 bits)}.
- R5: While a frame bit is being sent, a data bit of 0 drives `dout_pd` to 2'b11 and a data bit of 1 drives it to 2'b00. Outside frame bit cycles `dout_pd` is 2'b00. The two copies are always equal.
- R6: `txon_pd` is 2'b11 in exactly the frame bit cycles and 2'b00 in every other cycle.
- R7: End-of-readout is a pulse of one cycle, in the cycle right after the last frame bit. It appears on `end_a` when `path_sel`=0 and on `end_b` when `path_sel`=1; the other end output stays low.
- R8: With an event count of 0, no frame bits are sent. The end pulse appears in the cycle right after the start edge.
- R9: After the end pulse, every start pulse on either input is ignored until reset: the bus stays released and no end pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_id | input | 8 | Identifier placed at the head of every frame |
| path_sel | input | 1 | 0: use start_a/end_a, 1: use start_b/end_b |
| start_a | input | 1 | Start-of-readout token, path A |
| start_b | input | 1 | Start-of-readout token, path B |
| evt_count | input | 4 | Number of stored events (0 to 15) |
| mem_addr | output | 11 | Event memory read address {event, word} |
| mem_rdata | input | 14 | Event memory read data, combinational |
| dout_pd | output | 2 | Duplicated data-line pull-down enables |
| txon_pd | output | 2 | Duplicated transmit-active pull-down enables |
| end_a | output | 1 | End-of-readout pulse, path A |
| end_b | output | 1 | End-of-readout pulse, path B |

## Verification
The bench compares every frame bit against a stream it builds from the memory contents. This catches a field sent LSB first, a wrong field width, a channel word skipped or repeated, and a one-cycle gap between events. It also checks the cycle right after the start edge and the cycle right after the last bit. An off-by-one there would either leak an extra transmit cycle or fire the end pulse on top of the final bit.

An event count of zero must still pass the token at once. The bench also pulses the start input that is not selected, to catch a design that ORs both inputs. It also pulses both start inputs after the chain has passed this chip, to catch a design that goes round the chain a second time. Runs on path B and at the full depth of 15 events catch an end pulse on the wrong output and an event counter that wraps too early.

// File: rtl/tokchain_pkg.sv
package tokchain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_ENDP = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  // Width of frame field number widx: identifier, crossing ID, then channels.
  function automatic int field_bits(int widx, int id_w, int bc_w, int ch_w);
    if (widx == 0) return id_w;
    if (widx == 1) return bc_w;
    return ch_w;
  endfunction

  // Total bits of one event frame.
  function automatic int frame_bits(int id_w, int bc_w, int ch_w, int nch);
    return id_w + bc_w + nch * ch_w;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tok_path_sel.sv
module tok_path_sel (
  input  logic path_sel,
  input  logic start_a,
  input  logic start_b,
  input  logic end_pulse,
  output logic start_in,
  output logic end_a,
  output logic end_b
);
  always_comb begin
    start_in = path_sel ? start_b : start_a;
    end_a    = end_pulse & ~path_sel;
    end_b    = end_pulse &  path_sel;
  end
endmodule

// File: rtl/tok_sequencer.sv
module tok_sequencer
  import tokchain_pkg::*;
#(
  parameter int NCH    = 64,
  parameter int ID_W   = 8,
  parameter int BCID_W = 12,
  parameter int CH_W   = 14,
  parameter int CNT_W  = 4,
  parameter int WIDX_W = 7,
  parameter int BIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_in,
  input  logic [CNT_W-1:0]  evt_count,
  output logic              send_act,
  output logic              start_seen,
  output logic              end_pulse,
  output logic [CNT_W-1:0]  evt_idx,
  output logic [WIDX_W-1:0] word_idx,
  output logic [BIT_W-1:0]  bit_idx
);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NCH + 1);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   total_q;
  logic               last_bit, last_word, last_evt, frame_end;
  logic [WIDX_W-1:0]  nxt_widx;
  logic [BIT_W-1:0]   next_top;

  always_comb begin
    send_act   = (state_q == ST_SEND);
    start_seen = (state_q == ST_IDLE) && start_in;
    last_bit   = (bit_idx == '0);
    last_word  = (word_idx == LAST_WORD);
    last_evt   = (evt_idx == total_q - CNT_W'(1));
    frame_end  = send_act && last_bit && last_word && last_evt;
    nxt_widx   = last_word ? '0 : word_idx + WIDX_W'(1);
    next_top   = BIT_W'(field_bits(int'(nxt_widx), ID_W, BCID_W, CH_W) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      total_q   <= '0;
      evt_idx   <= '0;
      word_idx  <= '0;
      bit_idx   <= '0;
      end_pulse <= 1'b0;
    end else begin
      end_pulse <= (state_q == ST_ENDP);
      case (state_q)
        ST_IDLE: begin
          if (start_in) begin
            total_q  <= evt_count;
            evt_idx  <= '0;
            word_idx <= '0;
            bit_idx  <= BIT_W'(ID_W - 1);
            state_q  <= (evt_count == '0) ? ST_ENDP : ST_SEND;
          end
        end
        ST_SEND: begin
          if (last_bit) begin
            word_idx <= nxt_widx;
            bit_idx  <= next_top;
            if (last_word) evt_idx <= evt_idx + CNT_W'(1);
            if (frame_end) state_q <= ST_ENDP;
          end else begin
            bit_idx <= bit_idx - BIT_W'(1);
          end
        end
        ST_ENDP: state_q <= ST_DONE;
        default: state_q <= ST_DONE;
      endcase
    end
  end

  // R7
  end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> !end_pulse);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_DONE) && !send_act);

  // R4
  evt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_act |-> (evt_idx < total_q));

endmodule

// File: rtl/tok_serializer.sv
module tok_serializer #(
  parameter int ID_W   = 8,
  parameter int BCID_W = 12,
  parameter int CH_W   = 14,
  parameter int WIDX_W = 7,
  parameter int BIT_W  = 4,
  parameter int WW     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_act,
  input  logic [WIDX_W-1:0] word_idx,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [ID_W-1:0]   chip_id,
  input  logic [CH_W-1:0]   mem_rdata,
  output logic [1:0]        dout_pd,
  output logic [1:0]        txon_pd
);
  logic [WW-1:0] cur_word;
  logic          cur_bit;
  logic          dat_q, tx_q;

  always_comb begin
    cur_word = '0;
    if (word_idx == '0)
      cur_word[ID_W-1:0] = chip_id;
    else if (word_idx == WIDX_W'(1))
      cur_word[BCID_W-1:0] = mem_rdata[BCID_W-1:0];
    else
      cur_word[CH_W-1:0] = mem_rdata;
    cur_bit = cur_word[bit_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      tx_q  <= send_act;
      dat_q <= send_act & ~cur_bit;
    end
  end

  assign dout_pd = {2{dat_q}};
  assign txon_pd = {2{tx_q}};

  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txon_pd == 2'b00) |-> (dout_pd == 2'b00));

endmodule

// File: rtl/tokchain_readout.sv
module tokchain_readout
  import tokchain_pkg::*;
#(
  parameter int NCH     = 64,
  parameter int ID_W    = 8,
  parameter int BCID_W  = 12,
  parameter int VAL_W   = 12,
  parameter int EVT_MAX = 15,
  localparam int CH_W   = VAL_W + 2,
  localparam int CNT_W  = $clog2(EVT_MAX + 1),
  localparam int WIDX_W = $clog2(NCH + 2),
  localparam int ADDR_W = CNT_W + WIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   chip_id,
  input  logic              path_sel,
  input  logic              start_a,
  input  logic              start_b,
  input  logic [CNT_W-1:0]  evt_count,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [CH_W-1:0]   mem_rdata,
  output logic [1:0]        dout_pd,
  output logic [1:0]        txon_pd,
  output logic              end_a,
  output logic              end_b
);
  localparam int WW    = max3(ID_W, BCID_W, CH_W);
  localparam int BIT_W = $clog2(WW);

  logic              start_in, start_seen, send_act, end_pulse;
  logic [CNT_W-1:0]  evt_idx;
  logic [WIDX_W-1:0] word_idx;
  logic [BIT_W-1:0]  bit_idx;

  tok_path_sel u_path (
    .path_sel (path_sel),
    .start_a  (start_a),
    .start_b  (start_b),
    .end_pulse(end_pulse),
    .start_in (start_in),
    .end_a    (end_a),
    .end_b    (end_b)
  );

  tok_sequencer #(
    .NCH(NCH), .ID_W(ID_W), .BCID_W(BCID_W), .CH_W(CH_W),
    .CNT_W(CNT_W), .WIDX_W(WIDX_W), .BIT_W(BIT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_in  (start_in),
    .evt_count (evt_count),
    .send_act  (send_act),
    .start_seen(start_seen),
    .end_pulse (end_pulse),
    .evt_idx   (evt_idx),
    .word_idx  (word_idx),
    .bit_idx   (bit_idx)
  );

  // Memory word 0 holds the crossing ID, word ch+1 holds channel ch.
  always_comb begin
    mem_addr = {evt_idx, (word_idx == '0) ? WIDX_W'(0) : word_idx - WIDX_W'(1)};
  end

  tok_serializer #(
    .ID_W(ID_W), .BCID_W(BCID_W), .CH_W(CH_W),
    .WIDX_W(WIDX_W), .BIT_W(BIT_W), .WW(WW)
  ) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .send_act (send_act),
    .word_idx (word_idx),
    .bit_idx  (bit_idx),
    .chip_id  (chip_id),
    .mem_rdata(mem_rdata),
    .dout_pd  (dout_pd),
    .txon_pd  (txon_pd)
  );

  // R7
  end_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({end_a, end_b}));

  // R2
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txon_pd[0]) |-> $past(start_seen, 2));

  // R7
  tx_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txon_pd[0]) |-> end_pulse);

endmodule

// File: tb/tokchain_readout_tb.sv
`timescale 1ns/1ps
module tokchain_readout_tb;
  localparam int FB = 8 + 12 + 64 * 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  chip_id = 8'h00;
  logic        path_sel = 1'b0;
  logic        start_a = 1'b0;
  logic        start_b = 1'b0;
  logic [3:0]  evt_count = 4'd0;
  logic [10:0] mem_addr;
  logic [13:0] mem_rdata;
  logic [1:0]  dout_pd, txon_pd;
  logic        end_a, end_b;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tokchain_readout u_dut (
    .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .path_sel(path_sel),
    .start_a(start_a), .start_b(start_b), .evt_count(evt_count),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dout_pd(dout_pd), .txon_pd(txon_pd), .end_a(end_a), .end_b(end_b)
  );

  function automatic logic [13:0] mem_word(int e, int w);
    return 14'(((e * 613) + (w * 97) + 41) ^ (w << 5));
  endfunction

  assign mem_rdata = mem_word(int'(mem_addr[10:7]), int'(mem_addr[6:0]));

  // Expected bit k of the frame of event e (R4).
  function automatic logic exp_bit(logic [7:0] id, int e, int k);
    logic [13:0] wd;
    int c, b;
    if (k < 8) return id[7 - k];
    if (k < 20) begin
      wd = mem_word(e, 0);
      return wd[11 - (k - 8)];
    end
    c  = (k - 20) / 14;
    b  = 13 - ((k - 20) % 14);
    wd = mem_word(e, c + 1);
    return wd[b];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start_a = 1'b0;
    start_b = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start(bit on_b);
    if (on_b) start_b = 1'b1; else start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    start_b = 1'b0;
  endtask

  // Watch for a number of cycles that nothing drives the bus or the end outputs.
  task automatic expect_quiet(int cycles, string req);
    int busy = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txon_pd != 2'b00 || dout_pd != 2'b00 || end_a || end_b) busy++;
    end
    check(busy == 0, req, "bus or end active while it should stay idle", busy, 0);
  endtask

  // Full readout from a start pulse on the selected path, n events.
  task automatic run_readout(logic [7:0] id, bit sel, int n, string req);
    int bad_d = 0, bad_t = 0, bad_e = 0, bad_cp = 0;
    int first_k = -1;
    logic ex;
    chip_id   = id;
    path_sel  = sel;
    evt_count = 4'(n);
    @(negedge clk);
    pulse_start(sel);
    // cycle right after the start edge: still released (R2)
    check(txon_pd == 2'b00 && dout_pd == 2'b00 && !end_a && !end_b, "R2",
          "bus active in start-edge cycle", int'(txon_pd), 0);
    for (int e = 0; e < n; e++) begin
      for (int k = 0; k < FB; k++) begin
        @(negedge clk);
        ex = exp_bit(id, e, k);
        if (txon_pd != 2'b11) bad_t++;
        if (dout_pd[0] != dout_pd[1]) bad_cp++;
        if (dout_pd[0] != ~ex) begin
          bad_d++;
          if (first_k < 0) first_k = e * FB + k;
        end
        if (end_a || end_b) bad_e++;
      end
    end
    if (n > 0) begin
      check(bad_d == 0, "R4", $sformatf("%s frame bits wrong, first at %0d", req, first_k), bad_d, 0);
      check(bad_cp == 0, "R5", "data copies differ", bad_cp, 0);
      check(bad_t == 0, "R6", "transmit flag missing in bit cycle", bad_t, 0);
      check(bad_e == 0, "R7", "end pulse during frame", bad_e, 0);
    end
    @(negedge clk);
    check(txon_pd == 2'b00 && dout_pd == 2'b00, "R6", "bus not released after last bit",
          int'({txon_pd, dout_pd}), 0);
    check(end_a == !sel && end_b == sel, (n == 0) ? "R8" : "R7", "end pulse on wrong output or missing",
          int'({end_a, end_b}), sel ? 1 : 2);
    @(negedge clk);
    check(!end_a && !end_b, "R7", "end pulse longer than one cycle", int'({end_a, end_b}), 0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    @(negedge clk);
    check(dout_pd == 2'b00 && txon_pd == 2'b00, "R1", "bus in reset",
          int'({txon_pd, dout_pd}), 0);
    check(!end_a && !end_b, "R1", "end outputs in reset", int'({end_a, end_b}), 0);
    do_reset();
    check(dout_pd == 2'b00 && txon_pd == 2'b00 && !end_a && !end_b, "R1",
          "outputs after reset", int'({txon_pd, dout_pd, end_a, end_b}), 0);
  endtask

  task automatic t_single_event_a();
    do_reset();
    run_readout(8'hA5, 1'b0, 1, "single event path A");
  endtask

  task automatic t_zero_events();
    do_reset();
    run_readout(8'h5A, 1'b0, 0, "zero events");
    do_reset();
    run_readout(8'h11, 1'b1, 0, "zero events path B");
  endtask

  task automatic t_unselected_start();
    do_reset();
    path_sel  = 1'b0;
    evt_count = 4'd2;
    @(negedge clk);
    pulse_start(1'b1);
    expect_quiet(30, "R3");
    run_readout(8'h77, 1'b0, 2, "after ignored start_b");
    do_reset();
    path_sel = 1'b1;
    @(negedge clk);
    pulse_start(1'b0);
    expect_quiet(30, "R3");
  endtask

  task automatic t_path_b_three();
    do_reset();
    run_readout(8'h3C, 1'b1, 3, "three events path B");
  endtask

  task automatic t_after_done();
    do_reset();
    run_readout(8'hC3, 1'b0, 1, "before re-start");
    pulse_start(1'b0);
    expect_quiet(30, "R9");
    pulse_start(1'b1);
    expect_quiet(30, "R9");
  endtask

  task automatic t_full_depth();
    do_reset();
    run_readout(8'hF0, 1'b0, 15, "fifteen events");
  endtask

  initial begin
    t_reset_state();
    t_single_event_a();
    t_zero_events();
    t_unselected_start();
    t_path_b_three();
    t_after_done();
    t_full_depth();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule